// File: doc/BRIEF.md
# Carry-Skip Binary Adder

A combinational binary adder that sums two operands and a carry-in, giving a sum of the operand width and a carry-out. The same hardware serves unsigned and two's-complement operands. Each bit position produces a generate signal (both operand bits 1) and a propagate signal (the operand bits differ). The carry chain is cut into fixed-size sections of four bits. Inside each section the carry ripples from bit to bit. Each section also has a bypass multiplexer. When every bit of the section propagates, the multiplexer sends the section's incoming carry straight to its outgoing carry and the internal ripple is skipped.

The block has no clock, reset or state. The sum and carry-out settle from the inputs alone. The skip path always gives the same value as the ripple path would, so the results match a plain ripple adder bit for bit. The bypass only shortens the worst-case carry path through long runs of propagating bits. With the default width of 32 there are eight sections, and the carry-out of the top section is the adder's carry-out.

Top module: `cska_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`. This is the carry-out of the most significant section.
- R3: A section whose four bit positions all propagate (each bit pair differs) passes its incoming carry unchanged to its outgoing carry. When every bit of the operands propagates, `cout_o` equals `cin_i` and `sum_o` is all ones if `cin_i` is 0, or all zeros if `cin_i` is 1.
- R4: A section whose top bit generates (both operand bits 1) produces a carry-out of 1 whatever its carry-in.
- R5: A section in which every bit kills (both operand bits 0) produces a carry-out of 0 whatever its carry-in. With all-zero operands, `sum_o` equals `cin_i` and `cout_o` is 0.
- R6: The block is purely combinational. Outputs follow the inputs without any clock edge, and all-zero inputs give an all-zero sum and a zero carry-out.
- R7: Each section's bypass multiplexer output equals that section's internal ripple carry for every input.
- R8: No bit position ever has generate and propagate both at 1. The classes used are kill (g=0, p=0), propagate (g=0, p=1) and generate (g=1, p=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that uses the bypass in several sections in a row while other sections generate or kill. With random operands, four propagating bits in one section occur only about one time in sixteen, and chained skips are far rarer. An 8-bit copy of the adder (two sections) is therefore swept over every operand pair and both carry-in values, which covers every mix of skip, generate and kill. The 32-bit instance then gets hand-built patterns: alternating-complement operands that propagate across all eight sections, generating and killing sections placed between propagating ones, and a set of random vectors.

// File: rtl/cska_pkg.sv
package cska_pkg;

    // Per-bit carry behaviour, encoded as {generate, propagate}
    typedef enum logic [1:0] {
        GP_KILL  = 2'b00,
        GP_PROP  = 2'b01,
        GP_GEN   = 2'b10,
        GP_NEVER = 2'b11
    } gp_e;

    function automatic gp_e gp_classify(input logic g, input logic p);
        return gp_e'({g, p});
    endfunction

endpackage

// File: rtl/cska_section.sv
module cska_section
    import cska_pkg::*;
#(
    parameter int unsigned SW = 4
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  logic          cin_i,
    output logic [SW-1:0] sum_o,
    output logic          cout_o
);

    logic [SW-1:0] gen_d;
    logic [SW-1:0] prop_d;
    logic [SW:0]   rip_d;
    logic          allp_d;
    logic          cout_d;
    logic [SW-1:0] sum_d;

    always_comb begin
        gen_d    = a_i & b_i;
        prop_d   = a_i ^ b_i;
        rip_d    = '0;
        rip_d[0] = cin_i;
        for (int i = 0; i < SW; i++) begin
            rip_d[i+1] = gen_d[i] | (prop_d[i] & rip_d[i]);
        end
        allp_d = &prop_d;
        // bypass multiplexer: whole-section propagate selects the incoming carry
        cout_d = allp_d ? cin_i : rip_d[SW];
        sum_d  = prop_d ^ rip_d[SW-1:0];

        // R8: generate and propagate are never both set on one bit
        for (int i = 0; i < SW; i++) begin
            a_r8_gp_exclusive: assert (gp_classify(gen_d[i], prop_d[i]) != GP_NEVER)
                else $error("a_r8_gp_exclusive: bit %0d", i);
        end
        // R7: skip path and ripple path agree
        a_r7_skip_matches_ripple: assert (cout_d == rip_d[SW])
            else $error("a_r7_skip_matches_ripple");
        // R4: a generating top bit forces a section carry-out
        if (gen_d[SW-1]) begin
            a_r4_top_generate: assert (cout_d == 1'b1)
                else $error("a_r4_top_generate");
        end
        // R5: an all-kill section blocks any carry
        if ((gen_d | prop_d) == '0) begin
            a_r5_all_kill: assert (cout_d == 1'b0)
                else $error("a_r5_all_kill");
        end
        // R3: all-propagate section hands its carry-in through
        if (allp_d) begin
            a_r3_skip_pass: assert (cout_d == cin_i)
                else $error("a_r3_skip_pass");
        end
    end

    assign sum_o  = sum_d;
    assign cout_o = cout_d;

endmodule

// File: rtl/cska_chain.sv
module cska_chain #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SW    = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int unsigned NSECT = WIDTH / SW;

    logic [NSECT:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar j = 0; j < NSECT; j++) begin : g_sect
        cska_section #(.SW(SW)) u_sect (
            .a_i    (a_i[j*SW +: SW]),
            .b_i    (b_i[j*SW +: SW]),
            .cin_i  (carry_d[j]),
            .sum_o  (sum_o[j*SW +: SW]),
            .cout_o (carry_d[j+1])
        );
    end

    assign cout_o = carry_d[NSECT];

endmodule

// File: rtl/cska_adder.sv
module cska_adder #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SW    = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    // WIDTH must be a whole multiple of SW
    cska_chain #(.WIDTH(WIDTH), .SW(SW)) u_chain (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .sum_o  (sum_o),
        .cout_o (cout_o)
    );

endmodule

// File: tb/sim_cska_adder.sv
`timescale 1ns/1ps
module sim_cska_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // 32-bit instance
    logic [31:0] a, b, s;
    logic        ci, co;
    cska_adder #(.WIDTH(32), .SW(4)) u0 (
        .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));

    // 8-bit instance for the exhaustive sweep
    logic [7:0] sa, sb, ss;
    logic       sci, sco;
    cska_adder #(.WIDTH(8), .SW(4)) u1 (
        .a_i(sa), .b_i(sb), .cin_i(sci), .sum_o(ss), .cout_o(sco));

    task automatic check32(input logic [31:0] x, input logic [31:0] y,
                           input logic c, input string tag);
        logic [32:0] exp;
        a = x; b = y; ci = c;
        #1;
        exp = {1'b0, x} + {1'b0, y} + {32'd0, c};
        n_chk++;
        if (s !== exp[31:0] || co !== exp[32]) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%0d got sum=%h cout=%0d exp sum=%h cout=%0d",
                     tag, x, y, c, s, co, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        sa = '0; sb = '0; sci = 1'b0;
        @(negedge clk);

        // R6: all-zero inputs, no clock needed
        check32(32'h0, 32'h0, 1'b0, "R6 zero");
        // R5: all-kill operands, carry-in lands in sum only
        check32(32'h0, 32'h0, 1'b1, "R5 kill cin");
        // R3: every bit propagates, carry skips all sections
        check32(32'hFFFF_FFFF, 32'h0, 1'b1, "R3 full skip cin1");
        check32(32'hFFFF_FFFF, 32'h0, 1'b0, "R3 full skip cin0");
        check32(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1, "R3 mixed propagate");
        // R4: top bit of section 0 generates, carries into skipping sections
        check32(32'h0FFF_FFF8, 32'h0000_0008, 1'b0, "R4 gen then skip");
        check32(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 R4 top carry");
        // R5: kill section stops a carry between propagating sections
        check32(32'hFF0F_FFFF, 32'h0000_0000, 1'b1, "R5 kill mid");
        // R1/R2: two's complement cases
        check32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R1 minus1 plus1");
        check32(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R1 max positive");
        // R1/R2: random vectors
        for (int k = 0; k < 3000; k++) begin
            check32($urandom, $urandom, 1'($urandom), "R1 R2 random");
        end

        // R1 R2 R3 R4 R5 R7: exhaustive 8-bit sweep
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] exp8;
                    sa = 8'(i); sb = 8'(j); sci = 1'(c);
                    #1;
                    exp8 = 9'(i) + 9'(j) + 9'(c);
                    n_chk++;
                    if (ss !== exp8[7:0] || sco !== exp8[8]) begin
                        n_fail++;
                        $display("FAIL R1 R2 R7 sweep: a=%h b=%h cin=%0d got %0d/%h exp %0d/%h",
                                 i, j, c, sco, ss, exp8[8], exp8[7:0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule